// File: doc/BRIEF.md
# Rate-Matching Scan Sub-Chain Adapter

This block connects one fast external scan channel to several short internal sub-chains that shift at a fraction of the external rate. Serial bits arrive on `scan_in` one per fast clock. A lane register gathers them and presents one bit to each sub-chain. Once per group of `RATIO` fast cycles, a one-cycle strobe `sub_shift` tells every sub-chain to shift once. The sub-chains therefore toggle `RATIO` times less often than a single long chain clocked at the external rate, which lowers shift power by the same factor.

On the return side, a parallel-in/serial-out register samples all sub-chain outputs during the strobe cycle. It then plays them back on `scan_out` over the next group, one bit per fast cycle, lowest-numbered sub-chain first.

A group is `RATIO` fast cycles long. Only its first `NUM_SUB` positions carry data; the rest are idle slots. `RATIO` must be at least `NUM_SUB`. Deasserting `scan_en` stops the adapter and returns it to the start of a group.

Top module: `scan_rate_adapter`

## Requirements
- R1: While reset is asserted, `sub_shift` and `scan_out` are 0, and the group position returns to its first slot.
- R2: Number the fast cycles from 0, starting with the first cycle in which `scan_en` is high. While `scan_en` stays high, `sub_shift` is high for exactly one cycle at cycle `RATIO`, then again every `RATIO` cycles, and is low in every other cycle.
- R3: The `scan_in` bit taken at group position k, for k below `NUM_SUB`, is held on `sub_si[k]` during the strobe cycle that follows that group.
- R4: `scan_in` bits at group positions `NUM_SUB` through `RATIO-1` have no effect on `sub_si`.
- R5: During the group that begins with a strobe cycle, `scan_out` at position k (k below `NUM_SUB`) equals `sub_so[k]` as sampled in that strobe cycle. Bit 0 leaves in the strobe cycle itself.
- R6: `scan_out` is 0 at group positions `NUM_SUB` through `RATIO-1`.
- R7: During the first group after `scan_en` rises, `scan_out` is 0.
- R8: While `scan_en` is low, `scan_out` is 0 and no new strobe starts. When `scan_en` rises again, counting restarts at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Scan shift enable for the adapter |
| scan_in | input | 1 | Fast external serial scan input |
| scan_out | output | 1 | Fast external serial scan output |
| sub_si | output | NUM_SUB | Parallel scan inputs to the sub-chains |
| sub_so | input | NUM_SUB | Parallel scan outputs from the sub-chains |
| sub_shift | output | 1 | One-cycle shift strobe for the sub-chains |

## Verification
Any slip in the group counter shows at the ports within one group. The strobe lands on the wrong cycle, and every later group is misaligned. A lane register that captures at the wrong position hands the wrong bit to a sub-chain. That error reaches `scan_out` only after the word has passed through the sub-chains, so a bench modelling chains of length two sees it three groups later. A fault in the return register appears within the next group as a rotated or shifted output order, or as a nonzero value in an idle slot.

// File: rtl/sra_pkg.sv
package sra_pkg;

  // Width of a counter that spans 0 .. ratio-1 (never narrower than one bit).
  function automatic int unsigned slot_width(int unsigned ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction

  // True at the final position of a group.
  function automatic logic is_last_slot(logic [31:0] slot, int unsigned ratio);
    return slot == ratio - 1;
  endfunction

  // True at a group position that carries sub-chain data.
  function automatic logic is_lane_slot(logic [31:0] slot, int unsigned nsub);
    return slot < nsub;
  endfunction

endpackage

// File: rtl/sra_phase_ctr.sv
module sra_phase_ctr #(
  parameter int unsigned RATIO = 10,
  parameter int unsigned CNT_W = sra_pkg::slot_width(RATIO)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] slot,
  output logic             group_end,
  output logic             strobe
);
  logic [CNT_W-1:0] slot_q;
  logic             strobe_q;

  assign group_end = en && sra_pkg::is_last_slot(32'(slot_q), RATIO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         slot_q <= '0;
    else if (!en)       slot_q <= '0;
    else if (group_end) slot_q <= '0;
    else                slot_q <= slot_q + CNT_W'(1);
  end

  // The strobe is registered, so it arrives clean in the cycle after the group closes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= group_end;
  end

  assign slot   = slot_q;
  assign strobe = strobe_q;
endmodule

// File: rtl/sra_lane_sipo.sv
module sra_lane_sipo #(
  parameter int unsigned NUM_SUB = 4,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [CNT_W-1:0]   slot,
  input  logic               ser_in,
  output logic [NUM_SUB-1:0] lanes
);
  logic [NUM_SUB-1:0] hit;
  logic [NUM_SUB-1:0] lane_q;

  // One decode per lane: a lane loads only at its own position in the group.
  for (genvar k = 0; k < NUM_SUB; k++) begin : g_hit
    assign hit[k] = en && (slot == CNT_W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
    end else begin
      for (int k = 0; k < NUM_SUB; k++) begin
        if (hit[k]) lane_q[k] <= ser_in;
      end
    end
  end

  assign lanes = lane_q;
endmodule

// File: rtl/sra_lane_piso.sv
module sra_lane_piso #(
  parameter int unsigned NUM_SUB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               load,
  input  logic [NUM_SUB-1:0] par_in,
  output logic               ser_out
);
  logic [NUM_SUB-1:0] shreg_q;

  // Bit 0 goes out directly in the load cycle, so only bits 1.. are stored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg_q <= '0;
    else if (load)  shreg_q <= par_in >> 1;
    else if (!en)   shreg_q <= '0;
    else            shreg_q <= shreg_q >> 1;
  end

  assign ser_out = en && (load ? par_in[0] : shreg_q[0]);
endmodule

// File: rtl/scan_rate_adapter.sv
module scan_rate_adapter #(
  parameter int unsigned NUM_SUB = 4,
  parameter int unsigned RATIO   = 10,
  localparam int unsigned CNT_W  = sra_pkg::slot_width(RATIO)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               scan_in,
  output logic               scan_out,
  output logic [NUM_SUB-1:0] sub_si,
  input  logic [NUM_SUB-1:0] sub_so,
  output logic               sub_shift
);
  // Internal events, named so that the checker can observe them.
  logic [CNT_W-1:0] slot;
  logic             group_end;

  sra_phase_ctr #(.RATIO(RATIO), .CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (scan_en),
    .slot      (slot),
    .group_end (group_end),
    .strobe    (sub_shift)
  );

  sra_lane_sipo #(.NUM_SUB(NUM_SUB), .CNT_W(CNT_W)) u_sipo (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (scan_en),
    .slot   (slot),
    .ser_in (scan_in),
    .lanes  (sub_si)
  );

  sra_lane_piso #(.NUM_SUB(NUM_SUB)) u_piso (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (scan_en),
    .load    (sub_shift),
    .par_in  (sub_so),
    .ser_out (scan_out)
  );
endmodule

// File: rtl/sra_checker.sv
module sra_checker #(
  parameter int unsigned NUM_SUB = 4,
  parameter int unsigned RATIO   = 10,
  parameter int unsigned CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scan_en,
  input logic               scan_in,
  input logic               scan_out,
  input logic [NUM_SUB-1:0] sub_si,
  input logic [NUM_SUB-1:0] sub_so,
  input logic               sub_shift,
  input logic [CNT_W-1:0]   slot,
  input logic               group_end
);
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (slot == '0 && !sub_shift)); // R1

  AST_STROBE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    group_end |=> sub_shift); // R2

  if (RATIO > 1) begin : g_single
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sub_shift |=> !sub_shift); // R2
  end

  for (genvar k = 0; k < NUM_SUB; k++) begin : g_lane
    AST_LANE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en && slot == CNT_W'(k)) |=> (sub_si[k] == $past(scan_in))); // R3
  end

  AST_PAD_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en || 32'(slot) >= NUM_SUB) |=> $stable(sub_si)); // R4

  if (NUM_SUB > 1) begin : g_order
    AST_OUT_SECOND_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_shift && scan_en) |=> (!scan_en || scan_out == $past(sub_so[1]))); // R5
  end

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && 32'(slot) >= NUM_SUB && !sub_shift) |-> !scan_out); // R6

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (slot == '0)); // R8

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !sub_shift) |=> !sub_shift); // R8
endmodule

bind scan_rate_adapter sra_checker #(
  .NUM_SUB(NUM_SUB),
  .RATIO  (RATIO),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scan_en   (scan_en),
  .scan_in   (scan_in),
  .scan_out  (scan_out),
  .sub_si    (sub_si),
  .sub_so    (sub_so),
  .sub_shift (sub_shift),
  .slot      (slot),
  .group_end (group_end)
);

// File: tb/scan_rate_adapter_tb.sv
module scan_rate_adapter_tb;
  localparam int NS = 4;
  localparam int RT = 10;
  localparam int NG = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scan_en = 1'b0;
  logic          scan_in = 1'b0;
  logic          scan_out;
  logic [NS-1:0] sub_si;
  logic [NS-1:0] sub_so;
  logic          sub_shift;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  scan_rate_adapter #(.NUM_SUB(NS), .RATIO(RT)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .scan_in   (scan_in),
    .scan_out  (scan_out),
    .sub_si    (sub_si),
    .sub_so    (sub_so),
    .sub_shift (sub_shift)
  );

  // Environment: sub-chains of two flops each, shifting on the strobe.
  logic [NS-1:0] ch0, ch1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch0 <= '0;
      ch1 <= '0;
    end else if (sub_shift) begin
      ch1 <= ch0;
      ch0 <= sub_si;
    end
  end
  assign sub_so = ch1;

  typedef struct {
    bit            chk_out;
    logic          exp_out;
    string         t_out;
    logic          exp_stb;
    string         t_stb;
    bit            chk_si;
    logic [NS-1:0] exp_si;
    string         t_si;
  } exp_t;

  exp_t          q[$];
  logic [NS-1:0] dat [NG];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: sets the inputs for one cycle and queues what that cycle must show.
  task automatic drive(input logic en, input logic din, input exp_t e);
    @(negedge clk);
    scan_en = en;
    scan_in = din;
    q.push_back(e);
  endtask

  // Monitor: compares each cycle's outputs against the queued expectation.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.t_stb, 32'(sub_shift), 32'(e.exp_stb));
        if (e.chk_out) check(e.t_out, 32'(scan_out), 32'(e.exp_out));
        if (e.chk_si)  check(e.t_si, 32'(sub_si), 32'(e.exp_si));
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e = '{chk_out: 1'b1, exp_out: 1'b0, t_out: "R8", exp_stb: 1'b0, t_stb: "R8",
            chk_si: 1'b0, exp_si: '0, t_si: "R8"};
      drive(1'b0, 1'($urandom), e);
    end
  endtask

  // One enabled session. full = data checked end to end through the chain model.
  task automatic session(input int ngroups, input int tail, input bit full, input string stb_tag);
    for (int g = 0; g <= ngroups; g++) begin
      for (int c = 0; c < RT; c++) begin
        exp_t e;
        logic din;
        if (g == ngroups && c >= tail) break;
        din = (c < NS) ? dat[g][c] : 1'($urandom);  // idle slots get noise (R4)
        e.exp_stb = (c == 0 && g >= 1);
        e.t_stb   = stb_tag;
        e.chk_si  = full && e.exp_stb;
        e.exp_si  = (g >= 1) ? dat[g-1] : '0;
        e.t_si    = (g % 2 == 1) ? "R4" : "R3";
        if (c >= NS) begin
          e.chk_out = 1'b1; e.exp_out = 1'b0; e.t_out = "R6";
        end else if (g == 0) begin
          e.chk_out = 1'b1; e.exp_out = 1'b0; e.t_out = "R7";
        end else begin
          e.chk_out = full;
          e.exp_out = (g >= 3) ? dat[g-3][c] : 1'b0;  // two-flop chains: three groups round trip (R5)
          e.t_out   = "R5";
        end
        drive(1'b1, din, e);
      end
    end
  endtask

  initial begin
    dat[0] = '1;
    dat[1] = '0;
    dat[2] = 4'b0101;
    dat[3] = 4'b1010;
    dat[4] = 4'b0001;
    dat[5] = 4'b1000;
    for (int i = 6; i < NG; i++) dat[i] = NS'($urandom);

    // Reset state (R1)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 32'(sub_shift), 32'd0);
    check("R1", 32'(scan_out), 32'd0);
    rst_n = 1'b1;

    idle(4);
    // Main traffic: 12 full groups plus a partial one, so no strobe is pending at the stop.
    session(12, 5, 1'b1, "R2");
    // scan_en low: quiet output, no strobe (R8)
    idle(15);
    // Restart: strobe timing counted from the new rising edge (R8)
    session(3, 3, 1'b0, "R8");
    idle(3);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule